// File: doc/BRIEF.md
# Terminal-at-One Loadable Down Counter

This block is a programmable down counter for timing intervals. A start value is loaded with a one-cycle strobe. The counter then decrements by one on every clock in which its count enable is high. It halts when the count reaches one and raises a registered end-of-count flag. It stays halted until the next load.

The terminal value is one, not zero. A loaded zero therefore means the largest interval: the first step wraps the count to all-ones, and counting continues down to one. A load of zero covers 2^W counts, including the loaded state. All arithmetic is modulo 2^W.

The terminal condition is found from the borrow-out of a short chain of decrement stages, so there is no full-width comparator on the count. A load of one is recognised the same way, and it finishes the interval at once.

Top module: `dcnt_term1`

## Requirements
- R1: While busy, each clock edge with `cnt_en_i` high and `load_i` low lowers `count_o` by exactly one, modulo 2^W.
- R2: `eoc_o` rises at the same edge where `count_o` becomes 1. While `eoc_o` is high, `count_o` is 1.
- R3: From a loaded value of 0, the first enabled step gives all-ones. The count reaches 1 after 2^W-1 enabled steps.
- R4: `load_i` has priority over counting. At the next edge `count_o` equals `load_val_i`, even while busy with `cnt_en_i` high.
- R5: A load of 1 sets `eoc_o` high and `busy_o` low at the load edge, with zero enabled steps.
- R6: When halted (`busy_o` low), `cnt_en_i` is ignored. `count_o` stays 1 and `eoc_o` stays high until the next load.
- R7: Asserting `rst_ni` low gives `count_o` = 1, `eoc_o` = 1 and `busy_o` = 0, without waiting for a clock.
- R8: `busy_o` is high from a load of any value other than 1 until end of count. It is always the inverse of `eoc_o`.
- R9: An edge with `cnt_en_i` low and `load_i` low leaves `count_o` unchanged.
- R10: A load of V (V ≥ 2) reaches end of count after exactly V-1 enabled steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load strobe, one cycle |
| load_val_i | input | W | Start value; 0 means 2^W counts |
| cnt_en_i | input | 1 | Count enable |
| count_o | output | W | Current count |
| busy_o | output | 1 | Interval in progress |
| eoc_o | output | 1 | End-of-count flag, registered |

## Verification
The checker tests the following on every cycle:
- each decrement step, including the wrap from zero to all-ones;
- load priority;
- the immediate finish on a load of one;
- holding while halted or paused;
- the tie between `eoc_o`, `busy_o` and a count of one.

Some behaviour only the bench scenarios can show:
- the total number of enabled steps from each start value (0, 1, 2, 2^W-1 and others);
- the asynchronous reset state;
- a reload that cuts a running interval short.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;
  localparam int unsigned DCNT_W_DEF = 8;

  typedef enum logic {
    DCNT_IDLE = 1'b0,
    DCNT_RUN  = 1'b1
  } dcnt_state_e;
endpackage

// File: rtl/dcnt_borrow_chain.sv
// STAGES chained decrements of a_i; hit_o is the borrow out of the last
// stage, i.e. a_i == STAGES-1. dec_o is a_i - 1.
module dcnt_borrow_chain #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 1
) (
  input  logic [W-1:0] a_i,
  output logic [W-1:0] dec_o,
  output logic         hit_o
);
  logic [STAGES-1:0][W-1:0] val;
  logic [STAGES-1:0][W-1:0] brw;

  assign val[0] = a_i;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    assign brw[s][0] = 1'b1;
    for (genvar b = 1; b < W; b++) begin : g_bit
      assign brw[s][b] = brw[s][b-1] & ~val[s][b-1];
    end
    if (s < STAGES - 1) begin : g_mid
      assign val[s+1] = val[s] ^ brw[s];
    end else begin : g_last
      assign hit_o = brw[s][W-1] & ~val[s][W-1];
    end
  end

  assign dec_o = val[0] ^ brw[0];
endmodule

// File: rtl/dcnt_ctrl.sv
module dcnt_ctrl
  import dcnt_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         load_one_i,
  input  logic         cnt_en_i,
  input  logic [W-1:0] nxt_i,
  input  logic         land_i,
  output logic [W-1:0] cnt_o,
  output logic         run_o,
  output logic         eoc_o
);
  localparam logic [W-1:0] ONE = W'(1);

  dcnt_state_e state_q;
  logic [W-1:0] cnt_q;
  logic         eoc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= ONE;
      state_q <= DCNT_IDLE;
      eoc_q   <= 1'b1;
    end else if (load_i) begin
      cnt_q   <= load_val_i;
      state_q <= load_one_i ? DCNT_IDLE : DCNT_RUN;
      eoc_q   <= load_one_i;
    end else if (state_q == DCNT_RUN && cnt_en_i) begin
      cnt_q <= nxt_i;
      if (land_i) begin
        state_q <= DCNT_IDLE;
        eoc_q   <= 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign run_o = (state_q == DCNT_RUN);
  assign eoc_o = eoc_q;
endmodule

// File: rtl/dcnt_term1.sv
module dcnt_term1
  import dcnt_pkg::*;
#(
  parameter int unsigned W = DCNT_W_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         cnt_en_i,
  output logic [W-1:0] count_o,
  output logic         busy_o,
  output logic         eoc_o
);
  logic [W-1:0] cnt;
  logic [W-1:0] nxt;
  logic         land;
  logic [W-1:0] ld_dec_unused_n;
  logic         ld_one;

  // count == 2: next step lands on one
  dcnt_borrow_chain #(.W(W), .STAGES(3)) i_step (
    .a_i  (cnt),
    .dec_o(nxt),
    .hit_o(land)
  );

  // load value == 1
  dcnt_borrow_chain #(.W(W), .STAGES(2)) i_ldchk (
    .a_i  (load_val_i),
    .dec_o(ld_dec_unused_n),
    .hit_o(ld_one)
  );

  dcnt_ctrl #(.W(W)) i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_i),
    .load_val_i(load_val_i),
    .load_one_i(ld_one),
    .cnt_en_i  (cnt_en_i),
    .nxt_i     (nxt),
    .land_i    (land),
    .cnt_o     (cnt),
    .run_o     (busy_o),
    .eoc_o     (eoc_o)
  );

  assign count_o = cnt;

  logic unused_ok;
  assign unused_ok = ^ld_dec_unused_n;
endmodule

// File: rtl/dcnt_term1_chk.sv
module dcnt_term1_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         load_i,
  input logic [W-1:0] load_val_i,
  input logic         cnt_en_i,
  input logic [W-1:0] count_o,
  input logic         busy_o,
  input logic         eoc_o
);
  p_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cnt_en_i && !load_i) |=> count_o == W'($past(count_o) - 1'b1));

  p_eoc_one_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |-> count_o == W'(1));

  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cnt_en_i && !load_i && count_o == '0) |=> count_o == '1);

  p_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> count_o == $past(load_val_i));

  p_load_one_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && load_val_i == W'(1)) |=> (eoc_o && !busy_o));

  p_halt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !load_i) |=> ($stable(count_o) && eoc_o));

  p_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o != eoc_o);

  p_pause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_en_i && !load_i) |=> $stable(count_o));
endmodule

bind dcnt_term1 dcnt_term1_chk #(.W(W)) i_chk (.*);

// File: tb/test_dcnt_term1.sv
`timescale 1ns/1ps
module test_dcnt_term1;
  localparam int W = 8;
  localparam int FULL = (1 << W) - 1;
  localparam int NV = 6;
  // start value / expected enabled steps to end of count
  localparam int V_VAL   [NV] = '{0, 1, 2, FULL, 5, 128};
  localparam int V_STEPS [NV] = '{FULL, 0, 1, FULL - 1, 4, 127};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic load_i = 1'b0;
  logic [W-1:0] load_val_i = '0;
  logic cnt_en_i = 1'b0;
  logic [W-1:0] count_o;
  logic busy_o, eoc_o;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dcnt_term1 #(.W(W)) i_dcnt_term1 (
    .clk_i(clk), .rst_ni(rst_ni), .load_i(load_i), .load_val_i(load_val_i),
    .cnt_en_i(cnt_en_i), .count_o(count_o), .busy_o(busy_o), .eoc_o(eoc_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_load(input int v);
    load_i = 1'b1;
    load_val_i = W'(v);
    tick();
    load_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      finish_run();
    end
  end

  initial begin
    // R7: reset state
    repeat (3) tick();
    chk(count_o == 1, "R7 count", int'(count_o), 1);
    chk(eoc_o == 1'b1, "R7 eoc", int'(eoc_o), 1);
    chk(busy_o == 1'b0, "R7 busy", int'(busy_o), 0);
    rst_ni = 1'b1;
    tick();

    // R6: enable ignored while halted after reset
    cnt_en_i = 1'b1;
    repeat (3) tick();
    chk(count_o == 1 && eoc_o, "R6 halted after reset", int'(count_o), 1);

    // vector table: R1 R3 R5 R8 R10
    for (int k = 0; k < NV; k++) begin
      int steps;
      logic [W-1:0] e;
      cnt_en_i = 1'b1;
      do_load(V_VAL[k]);
      chk(count_o == W'(V_VAL[k]), "R4 load value", int'(count_o), V_VAL[k]);
      chk(busy_o == (V_VAL[k] != 1), "R8 busy after load", int'(busy_o), int'(V_VAL[k] != 1));
      if (V_VAL[k] == 1)
        chk(eoc_o == 1'b1, "R5 load one eoc", int'(eoc_o), 1);
      steps = 0;
      e = W'(V_VAL[k]);
      while (!eoc_o && steps < 2 * FULL) begin
        tick();
        steps++;
        e = e - 1'b1;
        if (count_o != e || (busy_o == eoc_o))
          chk(1'b0, "R1 step", int'(count_o), int'(e));
        if (V_VAL[k] == 0 && steps == 1)
          chk(count_o == W'(FULL), "R3 wrap", int'(count_o), FULL);
      end
      chk(steps == V_STEPS[k], (V_VAL[k] == 0) ? "R3 steps" : "R10 steps", steps, V_STEPS[k]);
      chk(count_o == 1 && eoc_o && !busy_o, "R2 terminal", int'(count_o), 1);
      // R6: stays halted
      repeat (2) tick();
      chk(count_o == 1 && eoc_o && !busy_o, "R6 hold", int'(count_o), 1);
    end

    // R9: pause
    cnt_en_i = 1'b0;
    do_load(10);
    repeat (3) tick();
    chk(count_o == 10 && busy_o, "R9 paused", int'(count_o), 10);
    cnt_en_i = 1'b1;
    tick();
    chk(count_o == 9, "R1 resume", int'(count_o), 9);

    // R4: reload mid-run with enable high
    do_load(20);
    repeat (3) tick();
    chk(count_o == 17, "R1 mid-run", int'(count_o), 17);
    do_load(7);
    chk(count_o == 7 && busy_o && !eoc_o, "R4 reload priority", int'(count_o), 7);
    tick();
    chk(count_o == 6, "R1 after reload", int'(count_o), 6);

    // R5: load one while running
    do_load(1);
    chk(count_o == 1 && eoc_o && !busy_o, "R5 load one mid-run", int'(count_o), 1);

    // R7: asynchronous reset mid-run
    do_load(50);
    tick();
    #1 rst_ni = 1'b0;
    #0.5;
    chk(count_o == 1 && eoc_o && !busy_o, "R7 async reset", int'(count_o), 1);
    tick();
    rst_ni = 1'b1;
    tick();
    chk(count_o == 1 && eoc_o, "R7 after release", int'(count_o), 1);

    finish_run();
  end
endmodule